// File: doc/BRIEF.md
# UART Receive FIFO

This block is the receive-side buffer of a serial port. A receiver front end hands it entries one at a time. Each entry is a received character with its error bits, or a break marker. The host takes entries out with a one-cycle read strobe. The head entry is always visible on `rd_data`, so the strobe simply consumes what is already shown. The buffer keeps a circular store addressed by a read index and a fill count. From that state it derives the empty and full flags. It also keeps a level-driven receive interrupt request, and it latches the error bits of every consumed entry into a status register.

A mode input selects between a queue of `DEPTH` entries and a single holding register. Any change of this input flushes the buffer. The push side is valid/ready. `in_ready` is high whenever the buffer can take an entry. Asserting `in_valid` while `in_ready` is low is not stalled: the entry is discarded and `overflow` pulses for one cycle, because a serial front end cannot hold its data back. The pop strobe, the status clear and the flags are plain level and strobe pins.

Top module: `uart_rx_store`

## Requirements
- R1: The store is circular with 16 entries. The read index advances by one per pop and wraps from 15 to 0. A push lands in slot (read index + count) mod 16, so entries leave in arrival order.
- R2: With `fifo_en`=1, `in_ready` is high while count < 16, and `full` is high exactly when count is 16.
- R3: With `fifo_en`=0, `in_ready` is high only while count is 0, and `full` is high as soon as one entry is held.
- R4: `empty` is high exactly when count is 0. Right after reset: `empty`=1, `full`=0, `rx_irq`=0, `rx_status`=0, `overflow`=0 and `rd_data`=0.
- R5: A push with `in_ready` low is dropped and leaves the stored entries unchanged. `overflow` is high for the one cycle after that edge.
- R6: `rd_data` always shows the entry at the read index. A pop while count is 0 leaves both the index and the count unchanged.
- R7: Entry bits 7:0 carry the character and bits 11:8 carry the error flags. When `in_break` is high, a push stores 0x400 (bit 10 set) whatever `in_data` holds.
- R8: Every pop copies bits 11:8 of the popped entry into `rx_status`. `stat_clr` clears `rx_status` to 0. When a pop and `stat_clr` arrive in the same cycle, the capture wins.
- R9: A cycle in which `fifo_en` differs from its previous value resets the count and the read index to 0. In that cycle the pop is ignored, and the push is dropped as in R5.
- R10: `rx_irq` is set when an accepted push leaves count equal to 1. It is cleared when a pop leaves count equal to 0, and that includes a pop on an empty buffer. Otherwise it holds its value.
- R11: A push and a pop in the same cycle leave the count unchanged. The pop returns the old head, and the push is written at the old index plus the old count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1 = 16-entry queue, 0 = single holding register |
| in_valid | input | 1 | Front end offers an entry |
| in_ready | output | 1 | Buffer can accept an entry this cycle |
| in_data | input | 12 | Entry: character in 7:0, error flags in 11:8 |
| in_break | input | 1 | Push a break marker (0x400) in place of `in_data` |
| rd_en | input | 1 | Host pop strobe |
| rd_data | output | 12 | Entry at the read index |
| stat_clr | input | 1 | Clear the receive status |
| rx_status | output | 4 | Error bits of the last popped entry |
| empty | output | 1 | Count is zero |
| full | output | 1 | No room for another entry in the current mode |
| rx_irq | output | 1 | Receive interrupt request (raw level) |
| overflow | output | 1 | One-cycle pulse after a dropped push |

## Verification
The bench uses the default parameters: depth 16, an 8-bit character field, 4 error bits and an interrupt trigger of 1. With only 16 slots, it can walk every fill level from empty to full and back. It can also send the read index around the wrap point several times and try every push, pop and clear combination against every mode transition. An arithmetic model of index, count, interrupt and status predicts every output after every cycle. This brings the corner cases within reach: pops on an empty buffer, pushes into a full buffer, a push and pop together at count 0, and a flush with entries still held.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_QUEUE  = 1'b1
  } rx_mode_e;

  // position of the break flag above the character field
  localparam int unsigned BRK_OFS = 2;
endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned EW    = 12,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [IW-1:0] wslot_i,
  input  logic [EW-1:0] wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [EW-1:0] rdata_o
);
  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int k = 0; k < DEPTH; k++) begin
      if (!rst_n) mem[k] <= '0;
      else if (we_i && wslot_i == IW'(k)) mem[k] <= wdata_i;
    end
  end

  assign rdata_o = mem[ridx_i];

  // R1: a write is stored in the addressed slot
  assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> mem[$past(wslot_i)] == $past(wdata_i));
endmodule

// File: rtl/rxb_ctrl.sv
module rxb_ctrl
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TRIG  = 1,
  localparam int unsigned IW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_i,
  input  logic          push_i,
  input  logic          pop_i,
  output logic          ready_o,
  output logic          accept_o,
  output logic          pop_take_o,
  output logic [IW-1:0] wslot_o,
  output logic [IW-1:0] ridx_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          irq_o,
  output logic          ovf_o
);
  rx_mode_e      mode_q;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic [IW-1:0] idx_q, idx_nxt;
  logic          irq_q, ovf_q;
  logic          toggle, room, deq;
  logic [CW:0]   slot_sum;

  assign toggle     = (rx_mode_e'(mode_i) != mode_q);
  assign room       = (mode_q == MODE_QUEUE) ? (cnt_q < CW'(DEPTH)) : (cnt_q == '0);
  assign ready_o    = !toggle && room;
  assign accept_o   = push_i && ready_o;
  assign pop_take_o = pop_i && !toggle;
  assign deq        = pop_take_o && (cnt_q != '0);

  always_comb begin
    slot_sum = (CW+1)'(idx_q) + (CW+1)'(cnt_q);
    if (slot_sum >= (CW+1)'(DEPTH)) wslot_o = IW'(slot_sum - (CW+1)'(DEPTH));
    else                            wslot_o = IW'(slot_sum);
  end

  always_comb begin
    if (toggle) begin
      cnt_nxt = '0;
      idx_nxt = '0;
    end else begin
      cnt_nxt = cnt_q + CW'(accept_o) - CW'(deq);
      if (deq) idx_nxt = (idx_q == IW'(DEPTH - 1)) ? '0 : idx_q + 1'b1;
      else     idx_nxt = idx_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_SINGLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      irq_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      mode_q <= rx_mode_e'(mode_i);
      cnt_q  <= cnt_nxt;
      idx_q  <= idx_nxt;
      ovf_q  <= push_i && !accept_o;
      if (!toggle) begin
        if (accept_o && cnt_nxt == CW'(TRIG))            irq_q <= 1'b1;
        else if (pop_take_o && cnt_nxt == CW'(TRIG - 1)) irq_q <= 1'b0;
      end
    end
  end

  assign ridx_o  = idx_q;
  assign empty_o = (cnt_q == '0);
  assign full_o  = (mode_q == MODE_QUEUE) ? (cnt_q == CW'(DEPTH)) : (cnt_q != '0);
  assign irq_o   = irq_q;
  assign ovf_o   = ovf_q;

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  assert_single_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SINGLE) |-> cnt_q <= CW'(1));
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !ready_o && !pop_i && !toggle) |=> cnt_q == $past(cnt_q));
  assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && cnt_q == '0 && !push_i && !toggle) |=> (idx_q == $past(idx_q) && cnt_q == '0));
  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != $past(mode_i)) |=> (cnt_q == '0 && idx_q == '0));
  assert_irq_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && !pop_i && cnt_q == CW'(TRIG - 1)) |=> irq_q);
  assert_both_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && pop_take_o && cnt_q != '0) |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/rxb_status.sv
module rxb_status #(
  parameter int unsigned EW     = 12,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned SW    = EW - DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop_i,
  input  logic          clr_i,
  input  logic [EW-1:0] entry_i,
  output logic [SW-1:0] status_o
);
  logic [SW-1:0] stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     stat_q <= '0;
    else if (pop_i) stat_q <= entry_i[EW-1:DATA_W];
    else if (clr_i) stat_q <= '0;
  end

  assign status_o = stat_q;

  assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |=> status_o == $past(entry_i[EW-1:DATA_W]));
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !pop_i) |=> status_o == '0);
endmodule

// File: rtl/uart_rx_store.sv
module uart_rx_store
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ERR_W  = 4,
  parameter int unsigned TRIG   = 1,
  localparam int unsigned EW    = DATA_W + ERR_W,
  localparam int unsigned IW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [EW-1:0]    in_data,
  input  logic             in_break,
  input  logic             rd_en,
  output logic [EW-1:0]    rd_data,
  input  logic             stat_clr,
  output logic [ERR_W-1:0] rx_status,
  output logic             empty,
  output logic             full,
  output logic             rx_irq,
  output logic             overflow
);
  localparam logic [EW-1:0] BREAK_ENTRY = EW'(1) << (DATA_W + BRK_OFS);

  logic          accept, pop_take;
  logic [IW-1:0] wslot, ridx;
  logic [EW-1:0] wdata;

  assign wdata = in_break ? BREAK_ENTRY : in_data;

  rxb_ctrl #(.DEPTH(DEPTH), .TRIG(TRIG)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (fifo_en),
    .push_i     (in_valid),
    .pop_i      (rd_en),
    .ready_o    (in_ready),
    .accept_o   (accept),
    .pop_take_o (pop_take),
    .wslot_o    (wslot),
    .ridx_o     (ridx),
    .empty_o    (empty),
    .full_o     (full),
    .irq_o      (rx_irq),
    .ovf_o      (overflow)
  );

  rxb_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (accept),
    .wslot_i (wslot),
    .wdata_i (wdata),
    .ridx_i  (ridx),
    .rdata_o (rd_data)
  );

  rxb_status #(.EW(EW), .DATA_W(DATA_W)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop_i    (pop_take),
    .clr_i    (stat_clr),
    .entry_i  (rd_data),
    .status_o (rx_status)
  );

  // R7: a break push stores the marker value
  assert_break_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_break && !rd_en) |=> !empty);
  assert_overflow_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> overflow);
endmodule

// File: tb/uart_rx_store_test.sv
module uart_rx_store_test;
  logic clk = 1'b0;
  logic rst_n, fifo_en, in_valid, in_ready, in_break, rd_en, stat_clr;
  logic [11:0] in_data, rd_data;
  logic [3:0]  rx_status;
  logic empty, full, rx_irq, overflow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [11:0] mm [16];
  int mi, mc;
  bit mq, mirq, mov, fen;
  logic [3:0] ms;

  always #5 clk = ~clk;

  uart_rx_store uut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_break(in_break), .rd_en(rd_en),
    .rd_data(rd_data), .stat_clr(stat_clr), .rx_status(rx_status), .empty(empty),
    .full(full), .rx_irq(rx_irq), .overflow(overflow)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive, predict, clock, compare
  task automatic step(input bit p, input logic [11:0] d, input bit b, input bit q, input bit c);
    bit tg, acc, dq, rdy;
    logic [11:0] old;
    int cn;
    in_valid = p; in_data = d; in_break = b; rd_en = q; stat_clr = c; fifo_en = fen;
    #1;
    tg  = (fen != mq);
    rdy = !tg && (mq ? (mc < 16) : (mc == 0));
    acc = p && rdy;
    chk(mq ? "R2" : "R3", int'(in_ready), int'(rdy));
    old = mm[mi];
    chk("R6", int'(rd_data), int'(old));
    if (tg) begin
      mc = 0; mi = 0; mq = fen;
      if (c) ms = 4'h0;
    end else begin
      if (acc) mm[(mi + mc) % 16] = b ? 12'h400 : d;
      dq = q && (mc > 0);
      cn = mc + int'(acc) - int'(dq);
      if (dq) mi = (mi + 1) % 16;
      mc = cn;
      if (acc && cn == 1) mirq = 1'b1;
      else if (q && cn == 0) mirq = 1'b0;
      if (q) ms = old[11:8];
      else if (c) ms = 4'h0;
    end
    mov = p && !acc;
    @(negedge clk);
    in_valid = 1'b0; rd_en = 1'b0; stat_clr = 1'b0; in_break = 1'b0;
    chk("R4", int'(empty), int'(mc == 0));
    chk(mq ? "R2" : "R3", int'(full), int'(mq ? (mc == 16) : (mc != 0)));
    chk("R10", int'(rx_irq), int'(mirq));
    chk("R8", int'(rx_status), int'(ms));
    chk("R5", int'(overflow), int'(mov));
    chk("R1", int'(rd_data), int'(mm[mi]));
  endtask

  task automatic summary;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 16; k++) mm[k] = 12'h000;
    mi = 0; mc = 0; mq = 1'b0; mirq = 1'b0; mov = 1'b0; ms = 4'h0; fen = 1'b0;
    rst_n = 1'b0; fifo_en = 1'b0; in_valid = 1'b0; in_data = '0; in_break = 1'b0;
    rd_en = 1'b0; stat_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R4 reset state
    chk("R4", int'(empty), 1); chk("R4", int'(full), 0); chk("R4", int'(rx_irq), 0);
    chk("R4", int'(rx_status), 0); chk("R4", int'(overflow), 0); chk("R4", int'(rd_data), 0);

    // R3 single-register mode: one entry, second one dropped (R5)
    step(1, 12'h1A5, 0, 0, 0);
    chk("R3", int'(full), 1);
    step(1, 12'h0B6, 0, 0, 0);
    chk("R5", int'(overflow), 1);
    step(0, 0, 0, 1, 0);
    chk("R8", int'(rx_status), 1);
    step(0, 0, 0, 0, 1);

    // R9 switch to queue mode, push in the flip cycle is dropped
    fen = 1'b1;
    step(1, 12'h0CC, 0, 0, 0);
    chk("R9", int'(empty), 1);

    // R2 fill sweep to 16 plus one overflow
    for (int i = 0; i < 17; i++) step(1, 12'((i * 37 + 5) & 255) | 12'((i % 16) << 8), 0, 0, 0);
    chk("R2", int'(full), 1);
    // drain, with extra pops on empty (R6)
    for (int i = 0; i < 18; i++) step(0, 0, 0, 1, 0);
    chk("R10", int'(rx_irq), 0);

    // R1 wrap across the index boundary
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 5 + r * 3; i++) step(1, 12'(r * 64 + i + 1), 0, 0, 0);
      for (int i = 0; i < 5 + r * 3; i++) step(0, 0, 0, 1, 0);
    end

    // R11 push and pop together at counts 0, 1 and 5
    step(1, 12'h311, 0, 1, 0);
    chk("R11", int'(empty), 0);
    step(1, 12'h322, 0, 1, 0);
    for (int i = 0; i < 4; i++) step(1, 12'(12'h340 + i), 0, 0, 0);
    step(1, 12'h355, 0, 1, 0);
    chk("R11", int'(rd_data), int'(mm[mi]));
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 0);

    // R7 break marker, R8 capture beats clear
    step(1, 12'h0FF, 1, 0, 0);
    chk("R7", int'(rd_data), 12'h400);
    step(0, 0, 0, 1, 1);
    chk("R8", int'(rx_status), 4);
    step(0, 0, 0, 0, 1);

    // R9 flush with entries held
    for (int i = 0; i < 3; i++) step(1, 12'(12'h900 + i), 0, 0, 0);
    fen = 1'b0;
    step(1, 12'h777, 0, 1, 0);
    chk("R9", int'(empty), 1);

    // near-exhaustive mix of push/pop/clear/break with mode flips
    for (int t = 0; t < 600; t++) begin
      if (t % 37 == 36) fen = !fen;
      step(((t * 7) % 5) < 3, 12'((t * 53 + 11) & 12'hFFF), (t % 11) == 3,
           ((t * 3) % 7) < 3, (t % 13) == 5);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule